// File: doc/BRIEF.md
# Pipelined SRAM Command Scheduler with Read-to-Write Turnaround

This block sits on the controller side of a pipelined synchronous SRAM link. Requests come in on a valid/ready port. Each request carries a direction, an address, write data, byte enables and a tag. The block issues each accepted request on the memory command lines one cycle later. Requests leave in the order they were accepted.

The upper address bits pick one of several banks. Only that bank's load strobe is raised. Direction, row address, write data and byte enables are wired to every bank alike.

The block keeps a minimum number of command-free cycles between a read and any write that follows it. The minimum is two, or three when the extended-gap setting is on. Other direction changes cost no idle cycles. While the gap is running, the request port holds ready low for a waiting write.

The tags of outstanding reads wait in an in-order queue. Each beat of returning data is accepted only when the memory's read-valid flag is high. The beat is then handed back with the oldest waiting tag. The flag is assumed to have been aligned to the data by the physical layer before it reaches this block.

Top module: `sram_cmd_sched`

## Requirements
- R1: Reset values. While `rst_n` is low and on the first cycle after it, all outputs are zero except `req_ready`. This covers `mem_ld`, `mem_wr`, `mem_addr`, `mem_wdata`, `mem_be`, `rsp_valid`, `rsp_tag` and `rsp_data`. `req_ready` is 1 after reset for either direction.
- R2: Issuing a request. A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on the memory lines right after that edge. Exactly one bit of `mem_ld` is 1, at index `req_addr[ADDR_W-1 -: BANK_BITS]`. `mem_addr` carries the low `ADDR_W-BANK_BITS` address bits. `mem_wr` is 1 for a write and 0 for a read. `mem_wdata` and `mem_be` carry the request's data and byte enables.
- R3: Idle cycles. On a cycle that follows an edge with no accepted request, every `mem_ld` bit is 0. `mem_wr`, `mem_addr`, `mem_wdata` and `mem_be` keep their previous values.
- R4: Normal read-to-write gap. With `cfg_gap3`=0, at least two command-free cycles separate an issued read from a later issued write. A write that is already waiting is held exactly two cycles with `req_ready` low.
- R5: Extended read-to-write gap. With `cfg_gap3`=1, the gap is at least three cycles, and a waiting write is held exactly three.
- R6: No-penalty transitions. Read after read, write after write and read after write are accepted on consecutive cycles with `req_ready` staying 1.
- R7: Ready and ordering. `req_ready` for a write (`req_write`=1) is low only while a read-to-write gap is running. Accepted requests appear on the memory lines in acceptance order.
- R8: Read responses. When `mem_rvalid` is 1 at an edge and at least one read is outstanding, `rsp_valid` is 1 for the following cycle. `rsp_data` then holds the `mem_rdata` sampled at that edge, and `rsp_tag` holds the tag of the oldest outstanding read. Tags come back in read-issue order.
- R9: Tag queue limit. With `TAGQ_DEPTH` reads outstanding, `req_ready` for a read (`req_write`=0) is 0. The write path is unaffected by this limit.
- R10: Stray read-valid. A `mem_rvalid` pulse with no read outstanding is ignored. `rsp_valid` stays 0, and later responses keep their normal tag order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_gap3 | input | 1 | 1 selects the three-cycle read-to-write gap |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Bank bits on top, row bits below |
| req_wdata | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables |
| req_tag | input | TAG_W | Tag returned with read data |
| mem_ld | output | NUM_BANKS | Per-bank load strobe, active high |
| mem_wr | output | 1 | Shared direction line, 1 write |
| mem_addr | output | ADDR_W-BANK_BITS | Shared row address |
| mem_wdata | output | DATA_W | Shared write data |
| mem_be | output | BE_W | Shared byte enables |
| mem_rvalid | input | 1 | Read data valid flag from memory |
| mem_rdata | input | DATA_W | Read data from memory |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | TAG_W | Tag of the returned read |
| rsp_data | output | DATA_W | Returned read data |

## Verification
A corrupted turnaround counter or last-direction record shows up on `req_ready` in the same cycle a write is offered. It also shows on the memory lines one cycle later, as a write too close to a read or as idle cycles where none are needed.

A wrong bank decode or stale shared-line register shows on `mem_ld` or `mem_addr` one cycle after acceptance.

A wrong queue pointer or count shows up later. It surfaces at the next `mem_rvalid`, as a wrong `rsp_tag` or as a missing or extra `rsp_valid`. It also shows whenever a read is offered with the queue near full.

The reference model is therefore compared on every cycle, not only at the end.

// File: rtl/sram_sched_pkg.sv
// Shared constants and types for the SRAM command scheduler.
// Assumes: gap lengths fit in NOP_W bits.
package sram_sched_pkg;
    localparam int NOP_W = 2;
    localparam logic [NOP_W-1:0] GAP_BASE = 2'd2;
    localparam logic [NOP_W-1:0] GAP_EXT  = 2'd3;

    typedef enum logic [1:0] {
        LAST_NONE  = 2'd0,
        LAST_READ  = 2'd1,
        LAST_WRITE = 2'd2
    } last_cmd_e;

    // Gap length required by the current configuration.
    function automatic logic [NOP_W-1:0] gap_need(input logic ext);
        return ext ? GAP_EXT : GAP_BASE;
    endfunction
endpackage

// File: rtl/turnaround_gate.sv
// Tracks the direction of the last issued command and the number of
// command-free cycles since it. Reports whether a write may issue now.
// Assumes: issue is the accept strobe of the top, one per cycle at most.
module turnaround_gate
    import sram_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_gap3,
    input  logic issue,
    input  logic issue_write,
    output logic write_ok
);
    last_cmd_e        last_q;
    logic [NOP_W-1:0] idle_q;

    // Record direction of each issued command; count idle cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_NONE;
            idle_q <= '0;
        end else if (issue) begin
            last_q <= issue_write ? LAST_WRITE : LAST_READ;
            idle_q <= '0;
        end else if (idle_q != {NOP_W{1'b1}}) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // A write waits only while a read is too recent.
    always_comb begin
        write_ok = (last_q != LAST_READ) || (idle_q >= gap_need(cfg_gap3));
    end

    logic rd_issue, wr_issue;
    assign rd_issue = issue && !issue_write;
    assign wr_issue = issue && issue_write;

    // R4: no write in either of the two cycles after a read
    a_r4_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> !wr_issue);
    a_r4_gap_second: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> ##1 !wr_issue);
    // R5: extended gap keeps the third cycle free as well
    a_r5_gap_third: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> ##2 !(wr_issue && cfg_gap3));
endmodule

// File: rtl/bank_decode.sv
// Registers the per-bank load strobes: one strobe for the bank named by
// the bank field of an issued command, none on idle cycles.
// Assumes: BANK_BITS >= 1.
module bank_decode #(
    parameter int BANK_BITS = 1,
    localparam int NUM_BANKS = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_BITS-1:0] bank,
    output logic [NUM_BANKS-1:0] ld_q
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        // Raise this bank's strobe for one cycle when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) ld_q[g] <= 1'b0;
            else        ld_q[g] <= issue && (bank == BANK_BITS'(g));
        end
    end

    // R2: exactly the addressed strobe follows an issue
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ($countones(ld_q) == 1) && ld_q[$past(bank)]);
    // R3: no strobe after an idle cycle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (ld_q == '0));
endmodule

// File: rtl/tag_queue.sv
// In-order queue of tags for reads that await data. A pop request on an
// empty queue is dropped.
// Assumes: push is never raised while full (the top gates it).
module tag_queue #(
    parameter int TAG_W = 4,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop_req,
    output logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             full
);
    logic [TAG_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             empty;

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign pop      = pop_req && !empty;
    assign head_tag = slot_q[rd_ptr_q];

    // Store the tag of each pushed read.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_tag;
    end

    // Advance pointers with explicit wrap and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push)
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9: the top never pushes into a full queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: occupancy stays within depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/sram_cmd_sched.sv
// Host-side command issuer for a pipelined synchronous SRAM. Accepts
// requests on a valid/ready port and issues them one cycle later on the
// shared memory lines plus one per-bank load strobe. Keeps the read-to-
// write gap and returns read data with the oldest outstanding tag.
// Assumes: mem_rvalid is already aligned to mem_rdata at this clock.
module sram_cmd_sched #(
    parameter int ADDR_W     = 12,
    parameter int BANK_BITS  = 1,
    parameter int DATA_W     = 16,
    parameter int BE_W       = 2,
    parameter int TAG_W      = 4,
    parameter int TAGQ_DEPTH = 4,
    localparam int NUM_BANKS = 1 << BANK_BITS,
    localparam int ROW_W     = ADDR_W - BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_gap3,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BE_W-1:0]      req_be,
    input  logic [TAG_W-1:0]     req_tag,
    output logic [NUM_BANKS-1:0] mem_ld,
    output logic                 mem_wr,
    output logic [ROW_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [BE_W-1:0]      mem_be,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 rsp_valid,
    output logic [TAG_W-1:0]     rsp_tag,
    output logic [DATA_W-1:0]    rsp_data
);
    logic             write_ok;
    logic             q_full;
    logic             accept;
    logic             pop;
    logic [TAG_W-1:0] head_tag;

    // Ready depends on the offered direction: gap for writes, space for reads.
    always_comb begin
        req_ready = req_write ? write_ok : !q_full;
    end
    assign accept = req_valid && req_ready;

    turnaround_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_gap3    (cfg_gap3),
        .issue       (accept),
        .issue_write (req_write),
        .write_ok    (write_ok)
    );

    bank_decode #(.BANK_BITS(BANK_BITS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (accept),
        .bank  (req_addr[ADDR_W-1 -: BANK_BITS]),
        .ld_q  (mem_ld)
    );

    tag_queue #(.TAG_W(TAG_W), .DEPTH(TAGQ_DEPTH)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept && !req_write),
        .push_tag (req_tag),
        .pop_req  (mem_rvalid),
        .pop      (pop),
        .head_tag (head_tag),
        .full     (q_full)
    );

    // Load the shared lines on issue; hold them through idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else if (accept) begin
            mem_wr    <= req_write;
            mem_addr  <= req_addr[ROW_W-1:0];
            mem_wdata <= req_wdata;
            mem_be    <= req_be;
        end
    end

    // Capture flagged read data together with the oldest waiting tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= pop;
            if (pop) begin
                rsp_tag  <= head_tag;
                rsp_data <= mem_rdata;
            end
        end
    end

    // R8: a response only follows a flagged beat
    a_r8_rsp_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_rvalid));
    // R8: response data is the beat sampled with the flag
    a_r8_rsp_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_data == $past(mem_rdata));
    // R3: shared lines hold when nothing was issued
    a_r3_hold_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mem_addr) && $stable(mem_wr) && $stable(mem_wdata));
endmodule

// File: tb/sram_cmd_sched_tb.sv
// Bench for sram_cmd_sched: a behavioural reference model (queue and
// counters) is stepped with every cycle and compared at the falling edge.
module sram_cmd_sched_tb;
    localparam int ADDR_W = 12, BANK_BITS = 1, DATA_W = 16, BE_W = 2;
    localparam int TAG_W = 4, DEPTH = 4;
    localparam int NB = 1 << BANK_BITS, ROW_W = ADDR_W - BANK_BITS;

    logic clk = 1'b0, rst_n = 1'b0, cfg_gap3 = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [NB-1:0]     mem_ld;
    logic              mem_wr, mem_rvalid = 1'b0, rsp_valid;
    logic [ROW_W-1:0]  mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata = '0, rsp_data;
    logic [BE_W-1:0]   mem_be;
    logic [TAG_W-1:0]  rsp_tag;

    always #10 clk = ~clk;   // 50 MHz

    sram_cmd_sched #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W),
        .BE_W(BE_W), .TAG_W(TAG_W), .TAGQ_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_gap3(cfg_gap3),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_tag(req_tag), .mem_ld(mem_ld), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    bit                m_last_rd = 0;
    int                m_idle = 0;
    logic [TAG_W-1:0]  m_q[$];
    logic [NB-1:0]     e_ld = '0;
    logic              e_wr = 0, e_rv = 0;
    logic [ROW_W-1:0]  e_addr = '0;
    logic [DATA_W-1:0] e_wd = '0, e_rdata = '0;
    logic [BE_W-1:0]   e_be = '0;
    logic [TAG_W-1:0]  e_tag = '0;
    logic              last_ready;
    logic [TAG_W-1:0]  next_tag = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic compare_outputs();
        chk("R2", "mem_ld", 64'(mem_ld), 64'(e_ld));
        chk("R2", "mem_wr", 64'(mem_wr), 64'(e_wr));
        chk("R3", "mem_addr", 64'(mem_addr), 64'(e_addr));
        chk("R3", "mem_wdata", 64'(mem_wdata), 64'(e_wd));
        chk("R2", "mem_be", 64'(mem_be), 64'(e_be));
        chk("R8", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk("R8", "rsp_tag", 64'(rsp_tag), 64'(e_tag));
        chk("R8", "rsp_data", 64'(rsp_data), 64'(e_rdata));
    endtask

    // One cycle: drive inputs, check ready, advance model, check outputs.
    task automatic step(input logic v, input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be,
                        input logic [TAG_W-1:0] t, input logic rv,
                        input logic [DATA_W-1:0] rd, input logic cfg);
        logic exp_ready;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        req_be = be; req_tag = t; mem_rvalid = rv; mem_rdata = rd; cfg_gap3 = cfg;
        #1;
        exp_ready = w ? (!m_last_rd || m_idle >= (cfg ? 3 : 2))
                      : (m_q.size() < DEPTH);
        chk(w ? "R7" : "R9", "req_ready", 64'(req_ready), 64'(exp_ready));
        last_ready = req_ready;
        if (rv && m_q.size() > 0) begin
            e_rv = 1; e_tag = m_q.pop_front(); e_rdata = rd;
        end else begin
            e_rv = 0;
        end
        if (v && exp_ready) begin
            e_ld = NB'(1) << a[ADDR_W-1 -: BANK_BITS];
            e_wr = w; e_addr = a[ROW_W-1:0]; e_wd = d; e_be = be;
            if (!w) m_q.push_back(t);
            m_last_rd = !w; m_idle = 0;
        end else begin
            e_ld = '0; m_idle++;
        end
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic idle(input logic rv, input logic [DATA_W-1:0] rd, input logic cfg);
        step(0, 0, '0, '0, '0, '0, rv, rd, cfg);
    endtask
    task automatic do_rd(input logic [ADDR_W-1:0] a, input logic cfg);
        step(1, 0, a, '0, '0, next_tag, 0, '0, cfg);
        next_tag++;
    endtask
    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic cfg);
        step(1, 1, a, d, 2'b11, '0, 0, '0, cfg);
    endtask

    // Offer a write right after a read and count the cycles ready stays low.
    task automatic gap_test(input logic cfg, input int want, input string req);
        int low = 0;
        do_rd(12'h005, cfg);
        for (int i = 0; i < 8; i++) begin
            do_wr(12'h806, 16'hA000 + 16'(i), cfg);
            if (last_ready) break;
            low++;
        end
        chk(req, "held cycles", 64'(low), 64'(want));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "mem_ld in reset", 64'(mem_ld), 64'd0);
        chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk("R1", "mem_addr in reset", 64'(mem_addr), 64'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "ready read after reset", 64'(req_ready), 64'd1);
        req_write = 1'b1; #1;
        chk("R1", "ready write after reset", 64'(req_ready), 64'd1);
        @(negedge clk);
        compare_outputs();

        // R2/R6: writes to both banks, back to back
        do_wr(12'h012, 16'h1111, 0);
        do_wr(12'h834, 16'h2222, 0);
        chk("R6", "write after write ready", 64'(last_ready), 64'd1);
        // R6: read straight after write, then read after read
        do_rd(12'h812, 0);
        chk("R6", "read after write ready", 64'(last_ready), 64'd1);
        do_rd(12'h013, 0);
        chk("R6", "read after read ready", 64'(last_ready), 64'd1);
        idle(1, 16'hBEEF, 0);
        idle(1, 16'hCAFE, 0);
        idle(0, '0, 0);
        // R4 and R5: waiting write held for the gap
        gap_test(0, 2, "R4");
        idle(1, 16'h0101, 0);
        gap_test(1, 3, "R5");
        idle(1, 16'h0202, 1);
        // R9: fill the tag queue, then a read is refused
        for (int i = 0; i < DEPTH; i++) do_rd(12'(i), 0);
        do_rd(12'h0FF, 0);
        chk("R9", "read refused when full", 64'(last_ready), 64'd0);
        next_tag--;
        // R9: a write is still taken once the gap has run
        idle(0, '0, 0);
        idle(0, '0, 0);
        do_wr(12'h0AA, 16'h5A5A, 0);
        chk("R9", "write taken while full", 64'(last_ready), 64'd1);
        // R8: drain in order
        for (int i = 0; i < DEPTH; i++) idle(1, 16'h3000 + 16'(i), 0);
        idle(0, '0, 0);
        // R10: stray flag with nothing outstanding
        idle(1, 16'hDEAD, 0);
        chk("R10", "no response on stray flag", 64'(rsp_valid), 64'd0);
        do_rd(12'h444, 0);
        idle(1, 16'h7777, 0);
        chk("R10", "next response valid", 64'(rsp_valid), 64'd1);

        // Mixed traffic against the model (R2..R10)
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 ADDR_W'($urandom), DATA_W'($urandom), BE_W'($urandom),
                 next_tag, $urandom_range(0, 2) == 0, DATA_W'($urandom),
                 (i / 150) % 2 == 1);
            next_tag++;
        end
        finish_run();
    end
endmodule